// File: doc/BRIEF.md
# Three-Symbol Two-of-Four Hierarchical Encoder

This block turns a 6-bit data word into a 12-wire pattern. The wires form three 4-wire groups, and every group always carries exactly two ones. The six weight-two words are split into three classes. Within each class, the two words differ in all four positions.

The data is carried on two levels. The upper three data bits choose the class of the two data groups, read as a base-3 pair. A third group carries a mod-3 checksum of those two classes. The lower three data bits then choose, for each group, which of the two words of its class goes on the wires. Because the two words of a class are four bits apart, a receiver that knows the class can repair any single flipped wire inside a group. Across the 12 wires the code delivers 6 bits, a rate of one half.

A word is accepted with a valid/ready handshake. The wire pattern is held in a register that changes only on the clock edge that completes the handshake.

Top module: `ncm_block_encoder`

## Requirements
- R1: Each 4-wire group of `wire_out` carries exactly two ones in every cycle, including during and after reset.
- R2: The classes are: class 0 = {0011, 1100}, class 1 = {0101, 1010}, class 2 = {0110, 1001}. Words are written with group bit 3 first. A pick bit of 0 sends the first listed word of the class and a pick bit of 1 sends the second.
- R3: The class of the checksum group equals (class of group 0 + class of group 1) mod 3.
- R4: With v = `in_data[5:3]`, group 0 takes class v/3 (integer division) and group 1 takes class v mod 3. The class pair (2,2) therefore never appears on the data groups.
- R5: `in_data[k]` is the pick bit of group k, for k = 0, 1, 2.
- R6: Group 0 occupies `wire_out[3:0]`, group 1 occupies `wire_out[7:4]`, and the checksum group occupies `wire_out[11:8]`.
- R7: `wire_out` takes the encoding of `in_data` on the rising edge where `in_valid` and `in_ready` are both high. On every other edge it holds its value.
- R8: While `rst_n` is low, `wire_out` is 12'h333 (class 0, pick 0 in every group) and `in_ready` is low. `in_ready` rises on the first edge after reset is released and then stays high.
- R9: The 64 data words produce 64 distinct wire patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A data word is offered |
| in_ready | output | 1 | The encoder accepts a word |
| in_data | input | 6 | Data word: [5:3] class pair value, [2:0] pick bits |
| wire_out | output | 12 | Registered pattern for the three 4-wire groups |

## Verification
Some properties are checked by assertions on every cycle:
- every group keeps a weight of two;
- the checksum group's class matches the mod-3 sum of the two data-group classes;
- the data groups never show the unused class pair (2,2);
- the output holds on any edge without a handshake;
- `in_ready` is high once reset is over.

Other properties can only be shown by the bench's scenarios. The exact class chosen for each value of the upper bits, the word chosen by each pick bit, and the group placement are checked by a full sweep of all 64 data words against values computed in the bench. That sweep also shows that all 64 patterns are distinct. The reset pattern and the holding of stale data while `in_valid` is low are checked with directed stimulus.

// File: rtl/ncm_enc_pkg.sv
package ncm_enc_pkg;
    localparam int SYM_W     = 4;
    localparam int NUM_SYM   = 3;
    localparam int RADIX     = 3;
    localparam int PICK_W    = NUM_SYM;
    localparam int PAIR_W    = 3;
    localparam int DATA_W    = PAIR_W + PICK_W;
    localparam int BUS_W     = SYM_W * NUM_SYM;
    localparam int CLS_W     = 2;
    localparam int SYM_ONES  = SYM_W / 2;

    typedef logic [CLS_W-1:0] cls_t;
    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        logic             rdy;
        logic [BUS_W-1:0] wires;
    } enc_state_t;

    // Reports the class of a weight-two word; 3 marks a word outside the code.
    function automatic cls_t class_of(input sym_t w);
        case (w)
            4'b0011, 4'b1100: class_of = 2'd0;
            4'b0101, 4'b1010: class_of = 2'd1;
            4'b0110, 4'b1001: class_of = 2'd2;
            default:          class_of = 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/class_pair_map.sv
module class_pair_map
    import ncm_enc_pkg::*;
(
    input  logic [PAIR_W-1:0] pair_val,
    output cls_t              cls_a,
    output cls_t              cls_b,
    output cls_t              cls_sum
);
    int   v_int;
    cls_t sum_raw;

    always_comb begin
        v_int   = int'(pair_val);
        cls_a   = cls_t'(v_int / RADIX);
        cls_b   = cls_t'(v_int % RADIX);
        sum_raw = cls_a + cls_b;
        cls_sum = (sum_raw >= cls_t'(RADIX)) ? sum_raw - cls_t'(RADIX) : sum_raw;
    end
endmodule

// File: rtl/class_word_pick.sv
module class_word_pick
    import ncm_enc_pkg::*;
(
    input  cls_t cls_in,
    input  logic pick,
    output sym_t word
);
    always_comb begin
        case (cls_in)
            2'd0:    word = pick ? 4'b1100 : 4'b0011;
            2'd1:    word = pick ? 4'b1010 : 4'b0101;
            default: word = pick ? 4'b1001 : 4'b0110;
        endcase
    end
endmodule

// File: rtl/ncm_block_encoder.sv
module ncm_block_encoder
    import ncm_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic [BUS_W-1:0]  wire_out
);
    localparam logic [BUS_W-1:0] RESET_WIRES = {NUM_SYM{4'b0011}};

    enc_state_t       st_d, st_q;
    cls_t             grp_cls [NUM_SYM];
    logic [BUS_W-1:0] enc_wires;
    logic             accept;

    class_pair_map u_map (
        .pair_val (in_data[DATA_W-1:PICK_W]),
        .cls_a    (grp_cls[0]),
        .cls_b    (grp_cls[1]),
        .cls_sum  (grp_cls[2])
    );

    for (genvar gi = 0; gi < NUM_SYM; gi++) begin : g_grp
        class_word_pick u_pick (
            .cls_in (grp_cls[gi]),
            .pick   (in_data[gi]),
            .word   (enc_wires[gi*SYM_W +: SYM_W])
        );
    end

    assign accept = in_valid && st_q.rdy;

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b1;
        if (accept) begin
            st_d.wires = enc_wires;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rdy   <= 1'b0;
            st_q.wires <= RESET_WIRES;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = st_q.rdy;
    assign wire_out = st_q.wires;

    for (genvar ai = 0; ai < NUM_SYM; ai++) begin : g_chk
        AST_TWO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(wire_out[ai*SYM_W +: SYM_W]) == SYM_ONES); // R1
    end

    AST_PARITY_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        class_of(wire_out[11:8]) ==
        cls_t'((int'(class_of(wire_out[3:0])) + int'(class_of(wire_out[7:4]))) % RADIX)); // R3

    AST_NO_PAIR_22: assert property (@(posedge clk) disable iff (!rst_n)
        !(class_of(wire_out[3:0]) == 2'd2 && class_of(wire_out[7:4]) == 2'd2)); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(wire_out)); // R7

    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready); // R8
endmodule

// File: tb/ncm_block_encoder_test.sv
module ncm_block_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  in_data = 6'd0;
    logic [11:0] wire_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [11:0] seen [64];

    always #5 clk = ~clk;

    ncm_block_encoder uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .wire_out (wire_out)
    );

    function automatic logic [3:0] word_for(input int cls, input bit pick);
        case (cls)
            0:       return pick ? 4'b1100 : 4'b0011;
            1:       return pick ? 4'b1010 : 4'b0101;
            default: return pick ? 4'b1001 : 4'b0110;
        endcase
    endfunction

    function automatic logic [11:0] expect_of(input logic [5:0] d);
        int v, c0, c1, c2;
        v  = int'(d[5:3]);
        c0 = v / 3;
        c1 = v % 3;
        c2 = (c0 + c1) % 3;
        return {word_for(c2, d[2]), word_for(c1, d[1]), word_for(c0, d[0])};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [5:0] d);
        @(negedge clk);
        in_data  = d;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset pattern and ready low during reset
        check("R8 reset wires", wire_out, 12'h333);
        check("R8 ready low in reset", {11'd0, in_ready}, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 ready after reset", {11'd0, in_ready}, 12'd1);

        // R2 R3 R4 R5 R6 R7: full sweep of data words
        for (int i = 0; i < 64; i++) begin
            send(6'(i));
            check("R2/R3/R4/R5/R6/R7 encode", wire_out, expect_of(6'(i)));
            seen[i] = wire_out;
            for (int g = 0; g < 3; g++) begin
                check("R1 weight two", 12'($countones(wire_out[g*4 +: 4])), 12'd2);
            end
        end

        // R9: all patterns distinct
        begin
            int dup = 0;
            for (int a = 0; a < 64; a++)
                for (int b = a + 1; b < 64; b++)
                    if (seen[a] == seen[b]) dup++;
            check("R9 distinct patterns", 12'(dup), 12'd0);
        end

        // R7: no handshake means the output holds
        send(6'b101_110);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_data = 6'(k * 13 + 1);
            @(negedge clk);
            check("R7 hold without valid", wire_out, expect_of(6'b101_110));
        end

        // R8: reset mid-run restores the reset pattern
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset restores pattern", wire_out, 12'h333);
        check("R8 ready drops in reset", {11'd0, in_ready}, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule